// File: doc/BRIEF.md
# Isolated Serial Compliance-Limit Link

This block holds both ends of a three-wire serial link that carries a compliance-limit setting across an isolation barrier. On the controller end, a request loads a voltage-limit code. Any code above the top usable value is clamped to that value. The controller then sends the code most significant bit first, using a divided serial clock and a data line. After the last bit it raises a latch line. On the remote end, a shift register takes in the bits on each rising serial clock. On the rising edge of the latch it copies them into the parallel code that drives the limit DAC. Each code step stands for one volt of limit.

One return wire runs back across the barrier and is inverted on the way. While the latch is low, it echoes the bit most recently captured by the remote register. The controller inverts each echoed bit again and collects the stream, then flags a readback mismatch when the stream differs from the word it sent. While the latch is high, the return wire carries the over-compliance flag instead. That flag is the OR of two comparator outputs, one for each polarity. The controller samples it before dropping the latch.

The link wires appear as ports on both ends. The surrounding design, or a bench, closes the loop and so stands in for the barrier.

Top module: `cmp_link_top`

## Requirements
- R1: After reset, busy, done, mismatch, ovc_status, ctl_sclk, ctl_sdata and ctl_latch are 0, dac_code is 0, and rem_ret_out is 1 (the inverse of an empty register bit).
- R2: A requested code_in greater than 127 is sent and loaded as 127, and codes 0 to 127 are sent unchanged, so dac_code never exceeds 127.
- R3: Bits go out most significant first, one bit per rising edge of ctl_sclk. ctl_sdata changes only while ctl_sclk is low, and ctl_sclk stays low while ctl_latch is high.
- R4: Every link phase lasts div_sel+1 clock cycles, with div_sel captured when the request is accepted. A frame is 24 shift phases, one latch phase and one status phase. done pulses for one cycle exactly 26*(div_sel+1) cycles after the accepting edge, and busy falls on that same edge.
- R5: dac_code changes only on the cycle after the remote end sees a rising edge on rem_latch, which is 24*(div_sel+1)+1 cycles after the accepting edge. It holds its previous value while a new frame is shifting.
- R6: While rem_latch is low, rem_ret_out is the inverse of the bit last shifted into the remote register. After a frame it therefore equals the inverse of bit 0 of the loaded code.
- R7: While rem_latch is high, rem_ret_out is the inverse of (ovc_pos OR ovc_neg).
- R8: At the end of a frame, mismatch becomes 1 if the re-inverted echo stream differs from the sent word, and 0 otherwise. It holds until the next frame ends.
- R9: At the end of a frame, ovc_status takes the re-inverted return line as sampled at the end of the status phase (1 means over-compliance). It holds until the next frame ends.
- R10: A start request that arrives while busy is 1 is ignored and does not alter the frame in progress or the code that gets loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for both ends |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send code_in; taken only when idle |
| code_in | input | 8 | Requested limit code in volts |
| div_sel | input | 8 | Phase length minus one, in clock cycles |
| ovc_pos | input | 1 | Positive-window comparator output |
| ovc_neg | input | 1 | Negative-window comparator output |
| ctl_ret_in | input | 1 | Return wire as seen on the controller end (inverted) |
| ctl_sclk | output | 1 | Serial clock driven by the controller |
| ctl_sdata | output | 1 | Serial data driven by the controller |
| ctl_latch | output | 1 | Latch driven by the controller |
| rem_sclk | input | 1 | Serial clock arriving at the remote end |
| rem_sdata | input | 1 | Serial data arriving at the remote end |
| rem_latch | input | 1 | Latch arriving at the remote end |
| rem_ret_out | output | 1 | Return wire driven by the remote end (inverted) |
| dac_code | output | 8 | Parallel code loaded into the DAC |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| mismatch | output | 1 | Readback of the last frame failed |
| ovc_status | output | 1 | Over-compliance state sampled in the last frame |

## Verification
A readback mismatch cannot happen while the loop is intact, because the remote end always echoes what it received. The bench therefore closes the loop itself, and while the latch is low it can flip the return wire on its way to the controller. This yields a frame with a corrupted echo but a clean status sample, so the mismatch flag and the status path are checked apart from each other. A second request is sent partway through a frame to show that it is dropped. Comparator patterns are set for each polarity in turn, and for both together.

// File: rtl/cmp_link_pkg.sv
package cmp_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_LATCH  = 2'd2,
    ST_STATUS = 2'd3
  } link_state_e;

  // sub-phases within one bit: data setup, clock high, clock low/echo sample
  localparam int unsigned PH_PER_BIT = 3;

  function automatic logic [31:0] clamp_code(input logic [31:0] code,
                                             input logic [31:0] limit);
    return (code > limit) ? limit : code;
  endfunction

  function automatic logic [31:0] frame_phases(input logic [31:0] nbits);
    return nbits * PH_PER_BIT + 32'd2;
  endfunction

endpackage

// File: rtl/cmp_link_divider.sv
module cmp_link_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cmp_link_ctrl.sv
module cmp_link_ctrl
  import cmp_link_pkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int CODE_MAX     = 127,
  parameter int DIV_W        = 8,
  parameter bit RET_INVERTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code_in,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              ret_in,
  output logic              sclk,
  output logic              sdata,
  output logic              latch,
  output logic              busy,
  output logic              done,
  output logic              mismatch,
  output logic              ovc_status,
  output logic              tick_o
);

  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

  link_state_e       state;
  logic [DIV_W-1:0]  div_q;
  logic [CODE_W-1:0] word;
  logic [CODE_W-1:0] rx;
  logic [IDX_W-1:0]  bit_idx;
  logic [1:0]        ph;
  logic              tick;
  logic              echo;
  logic              accept;
  logic [CODE_W-1:0] clamped;
  logic [IDX_W-1:0]  next_idx;

  generate
    if (RET_INVERTED) begin : g_ret_inv
      assign echo = ~ret_in;
    end else begin : g_ret_true
      assign echo = ret_in;
    end
  endgenerate

  assign clamped  = CODE_W'(clamp_code(32'(code_in), 32'(CODE_MAX)));
  assign accept   = start && (state == ST_IDLE);
  assign next_idx = bit_idx - 1'b1;
  assign busy     = (state != ST_IDLE);
  assign tick_o   = tick;

  cmp_link_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .div_val (div_q),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      div_q      <= '0;
      word       <= '0;
      rx         <= '0;
      bit_idx    <= '0;
      ph         <= '0;
      sclk       <= 1'b0;
      sdata      <= 1'b0;
      latch      <= 1'b0;
      done       <= 1'b0;
      mismatch   <= 1'b0;
      ovc_status <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            div_q   <= div_sel;
            word    <= clamped;
            rx      <= '0;
            bit_idx <= TOP_IDX;
            ph      <= 2'd0;
            sclk    <= 1'b0;
            sdata   <= clamped[CODE_W-1];
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            case (ph)
              2'd0: begin
                sclk <= 1'b1;
                ph   <= 2'd1;
              end
              2'd1: begin
                sclk <= 1'b0;
                ph   <= 2'd2;
              end
              default: begin
                rx <= {rx[CODE_W-2:0], echo};
                if (bit_idx == '0) begin
                  latch <= 1'b1;
                  state <= ST_LATCH;
                end else begin
                  bit_idx <= next_idx;
                  sdata   <= word[next_idx];
                  ph      <= 2'd0;
                end
              end
            endcase
          end
        end
        ST_LATCH: begin
          if (tick) begin
            state <= ST_STATUS;
          end
        end
        default: begin
          if (tick) begin
            ovc_status <= echo;
            mismatch   <= (rx != word);
            latch      <= 1'b0;
            done       <= 1'b1;
            state      <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cmp_link_remote.sv
module cmp_link_remote #(
  parameter int CODE_W       = 8,
  parameter bit RET_INVERTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              latch,
  input  logic              ovc_pos,
  input  logic              ovc_neg,
  output logic [CODE_W-1:0] dac_code,
  output logic              ret_out,
  output logic              shift_rise,
  output logic              latch_rise
);

  logic [CODE_W-1:0] sr;
  logic              sclk_d;
  logic              latch_d;
  logic              flag;
  logic              ret_raw;

  assign shift_rise = sclk && !sclk_d;
  assign latch_rise = latch && !latch_d;
  assign flag       = ovc_pos | ovc_neg;
  assign ret_raw    = latch ? flag : sr[0];

  generate
    if (RET_INVERTED) begin : g_drv_inv
      assign ret_out = ~ret_raw;
    end else begin : g_drv_true
      assign ret_out = ret_raw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      sclk_d   <= 1'b0;
      latch_d  <= 1'b0;
      dac_code <= '0;
    end else begin
      sclk_d  <= sclk;
      latch_d <= latch;
      if (shift_rise) begin
        sr <= {sr[CODE_W-2:0], sdata};
      end
      if (latch_rise) begin
        dac_code <= sr;
      end
    end
  end

endmodule

// File: rtl/cmp_link_top.sv
module cmp_link_top #(
  parameter int CODE_W       = 8,
  parameter int CODE_MAX     = 127,
  parameter int DIV_W        = 8,
  parameter bit RET_INVERTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code_in,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              ovc_pos,
  input  logic              ovc_neg,
  input  logic              ctl_ret_in,
  output logic              ctl_sclk,
  output logic              ctl_sdata,
  output logic              ctl_latch,
  input  logic              rem_sclk,
  input  logic              rem_sdata,
  input  logic              rem_latch,
  output logic              rem_ret_out,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              done,
  output logic              mismatch,
  output logic              ovc_status
);

  // named internal events, visible to the bound checker
  logic ctl_tick;
  logic rem_shift_rise;
  logic rem_latch_rise;

  cmp_link_ctrl #(
    .CODE_W       (CODE_W),
    .CODE_MAX     (CODE_MAX),
    .DIV_W        (DIV_W),
    .RET_INVERTED (RET_INVERTED)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .code_in    (code_in),
    .div_sel    (div_sel),
    .ret_in     (ctl_ret_in),
    .sclk       (ctl_sclk),
    .sdata      (ctl_sdata),
    .latch      (ctl_latch),
    .busy       (busy),
    .done       (done),
    .mismatch   (mismatch),
    .ovc_status (ovc_status),
    .tick_o     (ctl_tick)
  );

  cmp_link_remote #(
    .CODE_W       (CODE_W),
    .RET_INVERTED (RET_INVERTED)
  ) u_remote (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (rem_sclk),
    .sdata      (rem_sdata),
    .latch      (rem_latch),
    .ovc_pos    (ovc_pos),
    .ovc_neg    (ovc_neg),
    .dac_code   (dac_code),
    .ret_out    (rem_ret_out),
    .shift_rise (rem_shift_rise),
    .latch_rise (rem_latch_rise)
  );

endmodule

// File: rtl/cmp_link_checker.sv
module cmp_link_checker #(
  parameter int CODE_W       = 8,
  parameter int CODE_MAX     = 127,
  parameter bit RET_INVERTED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_sclk,
  input logic              ctl_sdata,
  input logic              ctl_latch,
  input logic              rem_latch,
  input logic              rem_ret_out,
  input logic              ovc_pos,
  input logic              ovc_neg,
  input logic [CODE_W-1:0] dac_code,
  input logic              busy,
  input logic              done,
  input logic              ctl_tick,
  input logic              rem_latch_rise
);

  logic flag_seen;
  assign flag_seen = ovc_pos || ovc_neg;

  a_r3_data_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sclk |-> $stable(ctl_sdata));

  a_r3_no_clock_under_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_latch |-> !ctl_sclk);

  a_r5_dac_follows_latch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(rem_latch_rise));

  a_r2_dac_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(dac_code) <= 32'(CODE_MAX));

  a_r7_status_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    rem_latch |-> (rem_ret_out == (RET_INVERTED ? !flag_seen : flag_seen)));

  a_r4_done_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r4_ticks_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_tick |-> busy);

endmodule

bind cmp_link_top cmp_link_checker #(
  .CODE_W       (CODE_W),
  .CODE_MAX     (CODE_MAX),
  .RET_INVERTED (RET_INVERTED)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_sclk       (ctl_sclk),
  .ctl_sdata      (ctl_sdata),
  .ctl_latch      (ctl_latch),
  .rem_latch      (rem_latch),
  .rem_ret_out    (rem_ret_out),
  .ovc_pos        (ovc_pos),
  .ovc_neg        (ovc_neg),
  .dac_code       (dac_code),
  .busy           (busy),
  .done           (done),
  .ctl_tick       (ctl_tick),
  .rem_latch_rise (rem_latch_rise)
);

// File: tb/cmp_link_top_bench.sv
module cmp_link_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] code_in = '0;
  logic [7:0] div_sel = '0;
  logic       ovc_pos = 1'b0;
  logic       ovc_neg = 1'b0;
  logic       corrupt = 1'b0;
  logic       ctl_ret_in, ctl_sclk, ctl_sdata, ctl_latch, rem_ret_out;
  logic [7:0] dac_code;
  logic       busy, done, mismatch, ovc_status;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // reference model state
  bit m_busy = 0;
  bit m_done = 0;
  int m_el = 0;
  int m_div = 0;
  int m_word = 0;
  int m_dac = 0;
  bit sbits[$];

  always #5 clk = ~clk;

  // the barrier: loop link wires, optionally corrupting the echo path
  assign ctl_ret_in = rem_ret_out ^ (corrupt & ~ctl_latch);

  cmp_link_top u_cmp_link_top (
    .clk(clk), .rst_n(rst_n), .start(start), .code_in(code_in), .div_sel(div_sel),
    .ovc_pos(ovc_pos), .ovc_neg(ovc_neg), .ctl_ret_in(ctl_ret_in),
    .ctl_sclk(ctl_sclk), .ctl_sdata(ctl_sdata), .ctl_latch(ctl_latch),
    .rem_sclk(ctl_sclk), .rem_sdata(ctl_sdata), .rem_latch(ctl_latch),
    .rem_ret_out(rem_ret_out), .dac_code(dac_code), .busy(busy), .done(done),
    .mismatch(mismatch), .ovc_status(ovc_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural timeline of a frame (R4, R5, R10)
  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_el = 0; m_dac = 0;
    end else if (m_busy) begin
      m_el++;
      if (m_el == 24 * (m_div + 1) + 1) m_dac = m_word;
      if (m_el == 26 * (m_div + 1)) begin
        m_busy = 0;
        m_done = 1;
      end
    end else if (start) begin
      m_busy = 1;
      m_el = 0;
      m_div = int'(div_sel);
      m_word = (code_in > 8'd127) ? 127 : int'(code_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 busy", int'(busy), int'(m_busy));
      chk("R4 done", int'(done), int'(m_done));
      chk("R5 dac", int'(dac_code), m_dac);
    end
  end

  always @(posedge ctl_sclk) sbits.push_back(ctl_sdata);

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic frame(input int code, input int dv, input bit p, input bit n,
                       input bit corr, input bit poke);
    int k = 0;
    int exp_word;
    int got;
    exp_word = (code > 127) ? 127 : code;
    sbits.delete();
    @(negedge clk);
    code_in = 8'(code);
    div_sel = 8'(dv);
    ovc_pos = p;
    ovc_neg = n;
    corrupt = corr;
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      k++;
      if (poke && k == 10) begin
        code_in = 8'h15;
        start = 1'b1;   // R10: must be dropped
      end
      if (done) break;
    end
    start = 1'b0;
    corrupt = 1'b0;
    chk("R4 frame length", k, 26 * (dv + 1) + 1);
    chk("R2 loaded code", int'(dac_code), exp_word);
    if (poke) chk("R10 request while busy ignored", int'(dac_code), exp_word);
    got = 0;
    foreach (sbits[i]) got = (got << 1) | int'(sbits[i]);
    chk("R3 bit count", sbits.size(), 8);
    chk("R3 msb-first stream", got, exp_word);
    chk("R8 mismatch", int'(mismatch), int'(corr));
    chk("R9 status", int'(ovc_status), int'(p | n));
    chk("R6 echo of last bit", int'(rem_ret_out), int'(~exp_word[0] & 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 dac", int'(dac_code), 0);
    chk("R1 flags", int'({done, mismatch, ovc_status}), 0);
    chk("R1 link", int'({ctl_sclk, ctl_sdata, ctl_latch}), 0);
    chk("R1 return idle", int'(rem_ret_out), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    frame(8'h5A, 0, 0, 0, 0, 0);
    frame(8'h01, 2, 1, 0, 0, 0);
    frame(127, 1, 0, 1, 0, 0);
    frame(200, 0, 1, 1, 0, 0);      // R2 clamp
    frame(255, 3, 0, 0, 0, 0);      // R2 clamp
    frame(8'h2C, 1, 1, 0, 1, 0);    // R8 corrupted echo, status intact
    frame(8'h2C, 1, 0, 0, 0, 0);    // R8 clears
    frame(8'h33, 2, 0, 1, 0, 1);    // R10

    // R7: latch low/high return behaviour checked at the ports directly
    @(negedge clk);
    ovc_pos = 1'b1;
    @(negedge clk);
    chk("R7 latch low ignores flag", int'(rem_ret_out), int'(~8'h33 & 1));

    // R5: dac holds while the next frame shifts
    @(negedge clk);
    code_in = 8'h07; div_sel = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R5 dac held mid-frame", int'(dac_code), 8'h33);
    while (!ctl_latch) @(negedge clk);
    chk("R7 flag on return", int'(rem_ret_out), 0);
    while (!done) @(negedge clk);
    chk("R9 status pos", int'(ovc_status), 1);
    chk("R5 dac after latch", int'(dac_code), 8'h07);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule